// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a small, fully associative cache of page translations serving one access side of a processor, instruction or data, picked by a parameter. A lookup presents a virtual page number and receives, one cycle later, a hit flag, a physical page number and a cacheable attribute. A fill port loads a new translation. A fill can be marked locked, which pins the slot against replacement and against global flushes.

Three maintenance commands act on the stored entries. Flush-all clears every unlocked entry. Invalidate-by-page clears the entries that match one virtual page, locked ones included. A locked entry cleared this way becomes a hole: the slot stays pinned but can never hit. Unlock-all releases every pin, which turns such holes back into free slots. When the MMU enable bit (bit 0 of the control register, wired to `mmu_en`) is low, lookups bypass the entries. They return an identity mapping and a fixed cacheability that depends on the side.

Each cycle the top module decodes its inputs into one command kind from an enumeration: none, fill, invalidate-page, flush-all or unlock-all. The enumerated kind selects the next-state update. The lookup is then matched against that updated state.

Top module: `lockable_tlb`

## Requirements
- R1: After reset no entry is valid or locked, the replacement pointer is at slot 0, and all response outputs are 0.
- R2: `lk_valid` is 1 exactly in the cycle after `lk_req`. A hit returns the stored physical page and cacheable bit. A miss, and any cycle without a response, returns `lk_hit`=0, `lk_ppn`=0 and `lk_cacheable`=0.
- R3: When several valid entries hold the requested page, the one with the lowest slot index supplies the result.
- R4: An unlocked fill writes the first unlocked slot at or after the round-robin pointer, searching upward and wrapping. The pointer then moves to the slot after the victim.
- R5: A locked fill writes the lowest-index slot that is both invalid and unlocked, and sets its lock flag without moving the pointer. If no such slot exists, it uses the round-robin victim as in R4.
- R6: A fill when every slot is locked changes nothing, and `fill_err` is 1 in the next cycle. Otherwise `fill_err` is 0.
- R7: Flush-all (`inv_all`) invalidates every unlocked entry. Locked entries keep their contents and still hit.
- R8: Invalidate-by-page (`inv_addr_req`, `inv_vpn`) invalidates every valid entry holding that page, locked or not. A locked slot cleared this way never hits and is never chosen by a fill until it is unlocked.
- R9: An invalidate-by-page that matches no valid entry leaves every stored translation unchanged.
- R10: Unlock-all clears every lock flag. Former holes become ordinary invalid slots that fills may allocate, and valid entries stay valid.
- R11: While `mmu_en` is 0, every lookup reports a hit with `lk_ppn` equal to the requested page. `lk_cacheable` equals 1 for the instruction side (`IS_INSTR`=1) and 0 for the data side.
- R12: A command in the same cycle as a lookup takes effect before the lookup, so the response reflects the updated entries.
- R13: When several commands arrive together, only the highest-priority one acts. The order from highest down is unlock-all, flush-all, invalidate-by-page, fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Bit 0 of the control register; 1 enables translation |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | PAGE_W | Virtual page to translate |
| lk_valid | output | 1 | Response present (one cycle after request) |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | PAGE_W | Physical page of the response |
| lk_cacheable | output | 1 | Cacheable attribute of the response |
| fill_req | input | 1 | Load a translation |
| fill_vpn | input | PAGE_W | Virtual page of the fill |
| fill_ppn | input | PAGE_W | Physical page of the fill |
| fill_cacheable | input | 1 | Cacheable attribute of the fill |
| fill_lock | input | 1 | Pin the filled slot |
| fill_err | output | 1 | Previous-cycle fill refused (all slots pinned) |
| inv_all | input | 1 | Flush all unlocked entries |
| inv_addr_req | input | 1 | Invalidate entries matching `inv_vpn` |
| inv_vpn | input | PAGE_W | Page to invalidate |
| unlock_all | input | 1 | Clear every lock flag |

## Verification
Several properties are checked on every cycle:
- the response timing of lookups;
- the clean zero payload on a miss;
- the identity mapping and side-specific cacheability in bypass;
- the agreement between the registered hit and the match vector;
- the refusal of fills once all slots are pinned;
- the suppression of fills by a higher-priority command.

Other behaviours depend on history across many cycles, and only the bench's scenarios can show them. These are the round-robin victim order, lowest-index selection among duplicates, holes that persist after invalidation and stop being allocated, their release by unlock, and flush survival of locked entries. The bench tracks them with its reference model.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;
    // Command kind decoded each cycle, lowest priority first
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_FILL,
        CMD_INV_ADDR,
        CMD_FLUSH,
        CMD_UNLOCK
    } cmd_e;
endpackage

// File: rtl/ltlb_match.sv
module ltlb_match #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/ltlb_first.sv
module ltlb_first #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ltlb_rr.sv
module ltlb_rr #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic          advance,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] ptr_q;

    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            j = (int'(ptr_q) + k) % N;
            if (elig[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance && found)
            ptr_q <= IW'((int'(idx) + 1) % N);
    end
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
    import ltlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int PAGE_W   = 20,
    parameter bit IS_INSTR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_en,
    input  logic              lk_req,
    input  logic [PAGE_W-1:0] lk_vpn,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic [PAGE_W-1:0] lk_ppn,
    output logic              lk_cacheable,
    input  logic              fill_req,
    input  logic [PAGE_W-1:0] fill_vpn,
    input  logic [PAGE_W-1:0] fill_ppn,
    input  logic              fill_cacheable,
    input  logic              fill_lock,
    output logic              fill_err,
    input  logic              inv_all,
    input  logic              inv_addr_req,
    input  logic [PAGE_W-1:0] inv_vpn,
    input  logic              unlock_all
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage and its next-state image
    logic [ENTRIES-1:0]             valid_q, lock_q, cach_q;
    logic [ENTRIES-1:0][PAGE_W-1:0] vpn_q, ppn_q;
    logic [ENTRIES-1:0]             valid_nx, lock_nx, cach_nx;
    logic [ENTRIES-1:0][PAGE_W-1:0] vpn_nx, ppn_nx;

    cmd_e cmd;

    logic [ENTRIES-1:0] inv_hits, lk_hits;
    logic               free_found, rr_found, lk_found;
    logic [IW-1:0]      free_idx, rr_idx, lk_idx, fill_slot;
    logic               use_free, fill_ok, rr_adv;

    // Command decode by fixed priority
    always_comb begin
        if (unlock_all)        cmd = CMD_UNLOCK;
        else if (inv_all)      cmd = CMD_FLUSH;
        else if (inv_addr_req) cmd = CMD_INV_ADDR;
        else if (fill_req)     cmd = CMD_FILL;
        else                   cmd = CMD_NONE;
    end

    ltlb_match #(.N(ENTRIES), .W(PAGE_W)) u_inv_match (
        .valid(valid_q), .tags(vpn_q), .key(inv_vpn), .hits(inv_hits)
    );

    ltlb_first #(.N(ENTRIES), .IW(IW)) u_free (
        .vec(~lock_q & ~valid_q), .found(free_found), .idx(free_idx)
    );

    ltlb_rr #(.N(ENTRIES), .IW(IW)) u_rr (
        .clk(clk), .rst_n(rst_n), .elig(~lock_q), .advance(rr_adv),
        .found(rr_found), .idx(rr_idx)
    );

    assign use_free  = fill_lock && free_found;
    assign fill_slot = use_free ? free_idx : rr_idx;
    assign fill_ok   = use_free || rr_found;
    assign rr_adv    = (cmd == CMD_FILL) && !use_free;

    // Next-state of the entry array for the decoded command
    always_comb begin
        valid_nx = valid_q;
        lock_nx  = lock_q;
        cach_nx  = cach_q;
        vpn_nx   = vpn_q;
        ppn_nx   = ppn_q;
        unique case (cmd)
            CMD_UNLOCK:   lock_nx  = '0;
            CMD_FLUSH:    valid_nx = valid_q & lock_q;
            CMD_INV_ADDR: valid_nx = valid_q & ~inv_hits;
            CMD_FILL: begin
                if (fill_ok) begin
                    valid_nx[fill_slot] = 1'b1;
                    lock_nx[fill_slot]  = fill_lock;
                    cach_nx[fill_slot]  = fill_cacheable;
                    vpn_nx[fill_slot]   = fill_vpn;
                    ppn_nx[fill_slot]   = fill_ppn;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            lock_q  <= '0;
            cach_q  <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else begin
            valid_q <= valid_nx;
            lock_q  <= lock_nx;
            cach_q  <= cach_nx;
            vpn_q   <= vpn_nx;
            ppn_q   <= ppn_nx;
        end
    end

    // Lookup sees the state after this cycle's command
    ltlb_match #(.N(ENTRIES), .W(PAGE_W)) u_lk_match (
        .valid(valid_nx), .tags(vpn_nx), .key(lk_vpn), .hits(lk_hits)
    );

    ltlb_first #(.N(ENTRIES), .IW(IW)) u_lk_first (
        .vec(lk_hits), .found(lk_found), .idx(lk_idx)
    );

    // Registered response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid     <= 1'b0;
            lk_hit       <= 1'b0;
            lk_ppn       <= '0;
            lk_cacheable <= 1'b0;
            fill_err     <= 1'b0;
        end else begin
            lk_valid <= lk_req;
            fill_err <= (cmd == CMD_FILL) && !fill_ok;
            if (!lk_req) begin
                lk_hit       <= 1'b0;
                lk_ppn       <= '0;
                lk_cacheable <= 1'b0;
            end else if (!mmu_en) begin
                lk_hit       <= 1'b1;
                lk_ppn       <= lk_vpn;
                lk_cacheable <= IS_INSTR;
            end else begin
                lk_hit       <= lk_found;
                lk_ppn       <= lk_found ? ppn_nx[lk_idx] : '0;
                lk_cacheable <= lk_found && cach_nx[lk_idx];
            end
        end
    end
endmodule

// File: rtl/lockable_tlb_chk.sv
module lockable_tlb_chk #(
    parameter int ENTRIES  = 8,
    parameter int PAGE_W   = 20,
    parameter bit IS_INSTR = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mmu_en,
    input logic               lk_req,
    input logic [PAGE_W-1:0]  lk_vpn,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [PAGE_W-1:0]  lk_ppn,
    input logic               lk_cacheable,
    input logic               fill_req,
    input logic               fill_err,
    input logic               inv_all,
    input logic               inv_addr_req,
    input logic               unlock_all,
    input logic [ENTRIES-1:0] lock_q,
    input logic [ENTRIES-1:0] lk_hits
);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    a_r2_idle_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!lk_valid && !lk_hit));

    a_r2_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_ppn == '0 && !lk_cacheable));

    a_r2_hit_tracks_match: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && mmu_en) |=> (lk_hit == $past(|lk_hits)));

    a_r11_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !mmu_en) |=>
            (lk_hit && lk_ppn == $past(lk_vpn) && lk_cacheable == IS_INSTR));

    a_r6_refuse_when_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !unlock_all && !inv_all && !inv_addr_req && (&lock_q)) |=> fill_err);

    a_r13_cmd_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_all || inv_all || inv_addr_req) |=> !fill_err);
endmodule

bind lockable_tlb lockable_tlb_chk #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .IS_INSTR(IS_INSTR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_cacheable(lk_cacheable),
    .fill_req(fill_req), .fill_err(fill_err), .inv_all(inv_all),
    .inv_addr_req(inv_addr_req), .unlock_all(unlock_all),
    .lock_q(lock_q), .lk_hits(lk_hits)
);

// File: tb/test_lockable_tlb.sv
module test_lockable_tlb;
    localparam int N = 8;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic         mmu_en, lk_req, fill_req, fill_cacheable, fill_lock;
    logic         inv_all, inv_addr_req, unlock_all;
    logic [W-1:0] lk_vpn, fill_vpn, fill_ppn, inv_vpn;

    logic         v_i, h_i, c_i, e_i, v_d, h_d, c_d, e_d;
    logic [W-1:0] p_i, p_d;

    lockable_tlb #(.ENTRIES(N), .PAGE_W(W), .IS_INSTR(1'b1)) i_lockable_tlb (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_valid(v_i), .lk_hit(h_i), .lk_ppn(p_i), .lk_cacheable(c_i),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_cacheable(fill_cacheable), .fill_lock(fill_lock), .fill_err(e_i),
        .inv_all(inv_all), .inv_addr_req(inv_addr_req), .inv_vpn(inv_vpn),
        .unlock_all(unlock_all)
    );

    lockable_tlb #(.ENTRIES(N), .PAGE_W(W), .IS_INSTR(1'b0)) i_lockable_tlb_d (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_valid(v_d), .lk_hit(h_d), .lk_ppn(p_d), .lk_cacheable(c_d),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_cacheable(fill_cacheable), .fill_lock(fill_lock), .fill_err(e_d),
        .inv_all(inv_all), .inv_addr_req(inv_addr_req), .inv_vpn(inv_vpn),
        .unlock_all(unlock_all)
    );

    // Behavioural reference model
    bit m_valid[N];
    bit m_lock[N];
    bit m_cach[N];
    int m_vpn[N];
    int m_ppn[N];
    int m_rr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic compare(input string tag, input string side, input logic v, input logic h,
                           input logic [W-1:0] p, input logic c, input logic e,
                           input logic xv, input logic xh, input logic [W-1:0] xp,
                           input logic xc, input logic xe);
        checks++;
        if (v !== xv || h !== xh || p !== xp || c !== xc || e !== xe) begin
            errors++;
            $display("FAIL %s side=%s got valid=%0b hit=%0b ppn=%h cach=%0b err=%0b expected valid=%0b hit=%0b ppn=%h cach=%0b err=%0b",
                     tag, side, v, h, p, c, e, xv, xh, xp, xc, xe);
        end
    endtask

    task automatic step(input string tag);
        logic         xv, xh, xci, xcd, xe;
        logic [W-1:0] xp;
        int           slot;
        xe = 1'b0;
        // Command first, by priority
        if (unlock_all) begin
            foreach (m_lock[i]) m_lock[i] = 1'b0;
        end else if (inv_all) begin
            foreach (m_valid[i]) if (!m_lock[i]) m_valid[i] = 1'b0;
        end else if (inv_addr_req) begin
            foreach (m_valid[i]) if (m_valid[i] && m_vpn[i] == int'(inv_vpn)) m_valid[i] = 1'b0;
        end else if (fill_req) begin
            slot = -1;
            if (fill_lock)
                foreach (m_valid[i]) if (slot < 0 && !m_valid[i] && !m_lock[i]) slot = i;
            if (slot < 0) begin
                for (int k = 0; k < N; k++)
                    if (slot < 0 && !m_lock[(m_rr + k) % N]) slot = (m_rr + k) % N;
                if (slot >= 0) m_rr = (slot + 1) % N;
            end
            if (slot < 0) xe = 1'b1;
            else begin
                m_valid[slot] = 1'b1;
                m_lock[slot]  = fill_lock;
                m_cach[slot]  = fill_cacheable;
                m_vpn[slot]   = int'(fill_vpn);
                m_ppn[slot]   = int'(fill_ppn);
            end
        end
        // Then the lookup against the updated model
        xv = lk_req; xh = 1'b0; xp = '0; xci = 1'b0; xcd = 1'b0;
        if (lk_req && !mmu_en) begin
            xh = 1'b1; xp = lk_vpn; xci = 1'b1; xcd = 1'b0;
        end else if (lk_req) begin
            slot = -1;
            foreach (m_valid[i]) if (slot < 0 && m_valid[i] && m_vpn[i] == int'(lk_vpn)) slot = i;
            if (slot >= 0) begin
                xh = 1'b1; xp = W'(m_ppn[slot]); xci = m_cach[slot]; xcd = m_cach[slot];
            end
        end
        @(posedge clk);
        #1;
        compare(tag, "instr", v_i, h_i, p_i, c_i, e_i, xv, xh, xp, xci, xe);
        compare(tag, "data",  v_d, h_d, p_d, c_d, e_d, xv, xh, xp, xcd, xe);
        lk_req = 1'b0; fill_req = 1'b0; inv_all = 1'b0; inv_addr_req = 1'b0;
        unlock_all = 1'b0; fill_lock = 1'b0;
    endtask

    task automatic fill(input int v, input int p, input bit c, input bit lk, input string tag);
        fill_req = 1'b1; fill_vpn = W'(v); fill_ppn = W'(p);
        fill_cacheable = c; fill_lock = lk;
        step(tag);
    endtask

    task automatic look(input int v, input string tag);
        lk_req = 1'b1; lk_vpn = W'(v);
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mmu_en = 1'b1; lk_req = 1'b0; fill_req = 1'b0;
        fill_cacheable = 1'b0; fill_lock = 1'b0; inv_all = 1'b0;
        inv_addr_req = 1'b0; unlock_all = 1'b0;
        lk_vpn = '0; fill_vpn = '0; fill_ppn = '0; inv_vpn = '0;
        foreach (m_valid[i]) begin
            m_valid[i] = 0; m_lock[i] = 0; m_cach[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
        end
        m_rr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        step("R1");
        look('h111, "R1");

        // R4 and R2: round-robin fills, then hits
        for (int i = 0; i < 3; i++) fill('h100 + i, 'h900 + i, i[0], 1'b0, "R4");
        for (int i = 0; i < 3; i++) look('h100 + i, "R2");
        look('h1FF, "R2");

        // R3: duplicate page, lowest slot wins
        fill('h100, 'hABC, 1'b1, 1'b0, "R3");
        look('h100, "R3");

        // R5: locked fill to the lowest free slot
        fill('h200, 'h7AA, 1'b1, 1'b1, "R5");
        look('h200, "R5");

        // R7: flush keeps the locked entry
        inv_all = 1'b1; step("R7");
        look('h101, "R7");
        look('h200, "R7");

        // R8: locked entry invalidated by page becomes a hole
        inv_addr_req = 1'b1; inv_vpn = W'('h200); step("R8");
        look('h200, "R8");
        for (int i = 0; i < N; i++) fill('h300 + i, 'hC00 + i, 1'b0, 1'b0, "R8");
        for (int i = 0; i < N; i++) look('h300 + i, "R8");
        look('h200, "R8");

        // R9: invalidate with no match
        inv_addr_req = 1'b1; inv_vpn = W'('h5FF); step("R9");
        for (int i = 1; i < N; i++) look('h300 + i, "R9");

        // R10: unlock frees the hole
        unlock_all = 1'b1; step("R10");
        for (int i = 0; i < N; i++) fill('h400 + i, 'hD00 + i, i[1], 1'b0, "R10");
        for (int i = 0; i < N; i++) look('h400 + i, "R10");

        // R12: command before lookup in the same cycle
        fill_req = 1'b1; fill_vpn = W'('h500); fill_ppn = W'('hE00); fill_cacheable = 1'b1;
        lk_req = 1'b1; lk_vpn = W'('h500); step("R12");
        inv_all = 1'b1; lk_req = 1'b1; lk_vpn = W'('h500); step("R12");

        // R13: priority between simultaneous commands
        inv_all = 1'b1; fill_req = 1'b1; fill_vpn = W'('h600); fill_ppn = W'('hF00); step("R13");
        look('h600, "R13");
        fill('h610, 'hF10, 1'b0, 1'b0, "R13");
        unlock_all = 1'b1; inv_addr_req = 1'b1; inv_vpn = W'('h610); step("R13");
        look('h610, "R13");

        // R6: pin every slot, then a refused fill
        for (int i = 0; i < N; i++) fill('h700 + i, 'h800 + i, 1'b1, 1'b1, "R6");
        for (int i = 0; i < N; i++) look('h700 + i, "R6");
        fill('h7FF, 'h8FF, 1'b0, 1'b1, "R6");
        fill('h7FE, 'h8FE, 1'b0, 1'b0, "R6");
        look('h7FF, "R6");
        inv_all = 1'b1; step("R7");
        look('h703, "R7");

        // R11: bypass with the MMU off
        mmu_en = 1'b0;
        look('h12345, "R11");
        look('h700, "R11");
        mmu_en = 1'b1;
        look('h700, "R11");
        step("R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule